// File: doc/BRIEF.md
# Dual-Bank Byte-Writable Memory Slice

This block is a storage slice with two independent synchronous RAM banks, called bank A and bank B, that sit behind one shared write port and one shared read port. The write port has its own clock, an address, a data word, a separate chip select for each bank and an active-low write enable for each byte lane. One write cycle can update bank A, bank B or both at the same address with the same data. Each bank stores only the lanes whose enables are low.

The read port runs on a clock of its own. On each rising read-clock edge the slice samples the read address and a one-bit bank select, then loads the chosen word into an output register. The read is always enabled, so every read-clock edge refreshes the output. Between edges the output holds its value. An asynchronous active-low reset in the read domain clears the output register. The banks themselves are not cleared.

A user must not read a word during the same cycle in which the other clock domain writes it. The result of such a collision is undefined.

Top module: `memslice`

## Requirements
- R1: While `rdRstN` is low, `rdData` is all zeros, asynchronously to `rdClk`.
- R2: With `wrCsA` high and `wrByteEnN` = 4'b0000 at a rising `wrClk`, `wrData` is stored in bank A at `wrAddr`. A read with `rdBankSel` = 0 returns it on `rdData` after the next rising `rdClk`.
- R3: With `wrCsB` high and all lanes enabled, the word is stored in bank B. A read with `rdBankSel` = 1 returns it.
- R4: A write with only one chip select high leaves the other bank's word at that address unchanged.
- R5: With both chip selects high, the same data is written at the same address in both banks.
- R6: The word is split into four 9-bit lanes. Lane i is bits [9i+8:9i] and is written only when `wrByteEnN[i]` is 0. Lanes whose enable is 1 keep their old content.
- R7: With both chip selects low, no bank is written, whatever the values of `wrByteEnN`, `wrAddr` and `wrData`.
- R8: `rdData` changes only on a rising `rdClk` (or on reset). While the read clock is stopped, the output holds even when the word it came from is rewritten.
- R9: There is no read enable. Every rising `rdClk` loads a new word, so back-to-back reads of different addresses or banks give one new result per cycle.
- R10: All 2048 words of each bank can be addressed. Address 0 and address 2047 hold distinct data in each bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| wrCsA | input | 1 | Write chip select for bank A, active high |
| wrCsB | input | 1 | Write chip select for bank B, active high |
| wrAddr | input | 11 | Write word address |
| wrData | input | 36 | Write data, four 9-bit lanes |
| wrByteEnN | input | 4 | Per-lane write enables, active low |
| rdClk | input | 1 | Read clock |
| rdRstN | input | 1 | Asynchronous reset of the output register, active low |
| rdBankSel | input | 1 | Read bank select: 0 selects bank A, 1 selects bank B |
| rdAddr | input | 11 | Read word address |
| rdData | output | 36 | Registered read data |

## Verification
A write takes effect at the rising `wrClk` where the chip select and lane enables are sampled. The bench updates its model of both banks only after that edge and deasserts the chip selects before any read is issued, so no read and write collide. A read result is due one rising `rdClk` after the address and select are driven. The driver sets them at the falling read edge and pushes the expected word into a queue, and the monitor pops and compares two nanoseconds after the following rising edge. The hold behaviour is checked by stopping the read clock, rewriting the displayed word, and confirming that `rdData` has not moved before the clock restarts.

// File: rtl/memslice_pkg.sv
package memslice_pkg;
  localparam int ADDR_W    = 11;
  localparam int NUM_LANES = 4;
  localparam int LANE_W    = 9;
  localparam int DATA_W    = NUM_LANES * LANE_W;
  localparam int NUM_BANKS = 2;

  // Write strobes from the control to the datapath: one lane-enable vector per bank.
  typedef struct packed {
    logic [NUM_BANKS-1:0][NUM_LANES-1:0] laneWe;
  } wrStrobe_t;
endpackage

// File: rtl/memslice_wrctl.sv
module memslice_wrctl
  import memslice_pkg::*;
(
  input  logic                 wrCsA,
  input  logic                 wrCsB,
  input  logic [NUM_LANES-1:0] wrByteEnN,
  output wrStrobe_t            wrStb
);
  logic [NUM_BANKS-1:0] bankCs;
  assign bankCs = {wrCsB, wrCsA};

  // A lane of a bank is written only when that bank is selected and the lane's low-true enable is asserted.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      assign wrStb.laneWe[b][l] = bankCs[b] & ~wrByteEnN[l];
    end
  end
endmodule

// File: rtl/memslice_bank.sv
module memslice_bank
  import memslice_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic                 wrClk,
  input  logic [AW-1:0]        wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LANES-1:0] laneWe,
  input  logic [AW-1:0]        rdAddr,
  output logic [DATA_W-1:0]    rdWord
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] store [DEPTH];

  // Write only the selected lanes; the other lanes keep what they held.
  always_ff @(posedge wrClk) begin
    for (int l = 0; l < NUM_LANES; l++) begin
      if (laneWe[l]) store[wrAddr][l*LANE_W +: LANE_W] <= wrData[l*LANE_W +: LANE_W];
    end
  end

  // Asynchronous array read; the datapath registers the result on the read clock.
  assign rdWord = store[rdAddr];
endmodule

// File: rtl/memslice_dp.sv
module memslice_dp
  import memslice_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic              wrClk,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  wrStrobe_t         wrStb,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdBankSel,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] bankWord [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    memslice_bank #(.AW(AW)) u_bank (
      .wrClk  (wrClk),
      .wrAddr (wrAddr),
      .wrData (wrData),
      .laneWe (wrStb.laneWe[b]),
      .rdAddr (rdAddr),
      .rdWord (bankWord[b])
    );
  end

  // Output register: there is no read enable, so it reloads on every read-clock edge.
  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) rdData <= '0;
    else         rdData <= bankWord[rdBankSel];
  end
endmodule

// File: rtl/memslice.sv
module memslice
  import memslice_pkg::*;
(
  input  logic                 wrClk,
  input  logic                 wrCsA,
  input  logic                 wrCsB,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LANES-1:0] wrByteEnN,
  input  logic                 rdClk,
  input  logic                 rdRstN,
  input  logic                 rdBankSel,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rdData
);
  wrStrobe_t wrStb;
  logic [NUM_BANKS-1:0][NUM_LANES-1:0] laneWeVec;

  memslice_wrctl u_ctl (
    .wrCsA     (wrCsA),
    .wrCsB     (wrCsB),
    .wrByteEnN (wrByteEnN),
    .wrStb     (wrStb)
  );

  memslice_dp #(.AW(ADDR_W)) u_dp (
    .wrClk     (wrClk),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .wrStb     (wrStb),
    .rdClk     (rdClk),
    .rdRstN    (rdRstN),
    .rdBankSel (rdBankSel),
    .rdAddr    (rdAddr),
    .rdData    (rdData)
  );

  assign laneWeVec = wrStb.laneWe;
endmodule

// File: rtl/memslice_chk.sv
module memslice_chk
  import memslice_pkg::*;
(
  input logic                                wrClk,
  input logic                                rstN,
  input logic                                wrCsA,
  input logic                                wrCsB,
  input logic [NUM_LANES-1:0]                wrByteEnN,
  input logic [NUM_BANKS-1:0][NUM_LANES-1:0] laneWe
);
  // R7
  no_cs_no_write_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (!wrCsA && !wrCsB) |-> (laneWe == '0));

  // R4
  single_bank_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrCsA && !wrCsB) |-> (laneWe[1] == '0));

  // R5
  dual_bank_same_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrCsA && wrCsB) |-> (laneWe[0] == laneWe[1]));

  // R6
  lane_mask_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    (($countones(laneWe[0]) <= $countones(~wrByteEnN)) &&
     ($countones(laneWe[1]) <= $countones(~wrByteEnN))));
endmodule

bind memslice memslice_chk u_chk (
  .wrClk     (wrClk),
  .rstN      (rdRstN),
  .wrCsA     (wrCsA),
  .wrCsB     (wrCsB),
  .wrByteEnN (wrByteEnN),
  .laneWe    (laneWeVec)
);

// File: tb/memslice_tb.sv
module memslice_tb;
  logic        wrClk = 0, rdPh = 0, rdRun = 1;
  logic        wrCsA = 0, wrCsB = 0;
  logic [10:0] wrAddr = '0, rdAddr = '0;
  logic [35:0] wrData = '0;
  logic [3:0]  wrByteEnN = 4'hF;
  logic        rdRstN = 0, rdBankSel = 0;
  logic [35:0] rdData;
  logic        rdClk;

  int nChecks = 0, nFails = 0;
  logic [35:0] modelA [int];
  logic [35:0] modelB [int];

  typedef struct { logic [35:0] exp; string tag; } item_t;
  item_t scq[$];

  always #10 wrClk = ~wrClk;        // 50 MHz
  initial begin #3; forever #10 rdPh = ~rdPh; end
  assign rdClk = rdPh & rdRun;

  memslice u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input bit a, input bit b, input int addr, input logic [35:0] d, input logic [3:0] benN);
    @(negedge wrClk);
    wrCsA = a; wrCsB = b; wrAddr = 11'(addr); wrData = d; wrByteEnN = benN;
    @(negedge wrClk);
    for (int l = 0; l < 4; l++) begin
      if (!benN[l]) begin
        if (a) begin
          if (!modelA.exists(addr)) modelA[addr] = '0;
          modelA[addr][l*9 +: 9] = d[l*9 +: 9];
        end
        if (b) begin
          if (!modelB.exists(addr)) modelB[addr] = '0;
          modelB[addr][l*9 +: 9] = d[l*9 +: 9];
        end
      end
    end
    wrCsA = 0; wrCsB = 0; wrByteEnN = 4'hF;
  endtask

  task automatic doRead(input bit sel, input int addr, input string tag);
    item_t it;
    @(negedge rdClk);
    rdBankSel = sel; rdAddr = 11'(addr);
    it.exp = sel ? modelB[addr] : modelA[addr];
    it.tag = tag;
    scq.push_back(it);
  endtask

  task automatic drain();
    while (scq.size() != 0) @(posedge wrClk);
    #5;
  endtask

  // Monitor: each result is due just after the rising read edge that follows the push.
  always @(posedge rdClk) begin
    #2;
    if (scq.size() != 0) begin
      item_t it;
      it = scq.pop_front();
      check(rdData === it.exp, it.tag, rdData, it.exp);
    end
  end

  initial begin : watchdog
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [35:0] held;
    #5;
    check(rdData === 36'h0, "R1 reset", rdData, 36'h0);
    #40; rdRstN = 1;

    // R2 / R3: full-word writes to each bank
    doWrite(1, 0, 5, 36'hA_1111_1111, 4'b0000);
    doWrite(0, 1, 5, 36'hB_2222_2222, 4'b0000);
    doRead(0, 5, "R2 bank A read");
    doRead(1, 5, "R3 bank B read");
    drain();

    // R4: single chip select leaves other bank alone
    doWrite(1, 0, 5, 36'h3_3333_3333, 4'b0000);
    doRead(1, 5, "R4 bank B unchanged");
    doRead(0, 5, "R4 bank A updated");
    drain();

    // R5: both chip selects
    doWrite(1, 1, 9, 36'h4_4444_4444, 4'b0000);
    doRead(0, 9, "R5 bank A dual write");
    doRead(1, 9, "R5 bank B dual write");
    drain();

    // R6: lane masking
    doWrite(1, 0, 9, 36'h5_5555_5555, 4'b1010);
    doRead(0, 9, "R6 lanes 0 and 2");
    doWrite(1, 0, 9, 36'hF_FFFF_FFFF, 4'b0111);
    doRead(0, 9, "R6 lane 3 only");
    doRead(1, 9, "R6 bank B untouched");
    drain();

    // R7: no chip select, enables low
    doWrite(0, 0, 5, 36'h6_6666_6666, 4'b0000);
    doRead(0, 5, "R7 bank A no write");
    doRead(1, 5, "R7 bank B no write");
    drain();

    // R10: address extremes
    doWrite(1, 0, 0,    36'h0_0000_0A0A, 4'b0000);
    doWrite(1, 0, 2047, 36'h7_FF00_FF00, 4'b0000);
    doWrite(0, 1, 0,    36'h1_2345_6789, 4'b0000);
    doWrite(0, 1, 2047, 36'h9_8765_4321, 4'b0000);
    doRead(0, 0,    "R10 A addr 0");
    doRead(0, 2047, "R10 A addr 2047");
    doRead(1, 0,    "R10 B addr 0");
    doRead(1, 2047, "R10 B addr 2047");
    drain();

    // R9: back-to-back reads, one new result per edge
    doRead(0, 9, "R9 b2b 1");
    doRead(1, 5, "R9 b2b 2");
    doRead(0, 2047, "R9 b2b 3");
    doRead(1, 0, "R9 b2b 4");
    drain();

    // R8: output holds while read clock stopped
    doRead(0, 5, "R8 before stop");
    drain();
    @(negedge rdPh); rdRun = 0;
    held = rdData;
    doWrite(1, 0, 5, 36'h8_8888_8888, 4'b0000);
    repeat (3) @(negedge wrClk);
    check(rdData === held, "R8 hold while clock stopped", rdData, held);
    @(negedge rdPh); rdRun = 1;
    doRead(0, 5, "R8 after restart");
    drain();

    // R1: reset mid-run clears output at once
    #1; rdRstN = 0; #2;
    check(rdData === 36'h0, "R1 async reset", rdData, 36'h0);
    #30; rdRstN = 1;

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule